// File: doc/BRIEF.md
# Self-Fetching CRC-16 Checksum Engine

This block computes a 16-bit CRC with the generator polynomial x^16 + x^12 + x^5 + 1 over a block of 16-bit words in memory. Once started, it reads those words itself, so the processor does not spend cycles loading operands. Software programs a byte start address, a length in words and a seed through a small register window. It then writes the go bit and is free to run other code. Completion shows up as a status flag and, when enabled, as an interrupt level. A single read of the result register returns the checksum.

Inside, a fetch unit acts as a bus master on a memory read port that uses a request/valid handshake with variable latency. It keeps one word in a prefetch buffer. A CRC datapath folds each word into the running remainder over several cycles, a parameterised number of bits per cycle. The fetch unit requests the next word while the current word is being folded, so memory latency is hidden behind the computation.

Top module: `crc_dma_engine`

## Requirements
- R1: After reset, status reads 0 (not busy, not done), result reads 0, `irq` is 0 and `mem_req` is 0.
- R2: Register window (byte offsets): 0x00 control (bit 0 go, write-only pulse; bit 1 interrupt enable, read back in bit 1); 0x04 status (bit 0 busy, bit 1 done); 0x08 start byte address; 0x0C word count (16 bits); 0x10 seed (16 bits); 0x14 result (read-only). Address, count, seed and interrupt enable read back as written.
- R3: The result equals the CRC of the block, with each word fed most significant bit first into a remainder that starts at the seed. Each input bit is XORed with the remainder's top bit, the remainder shifts left, and 0x1021 is XORed in when that XOR was 1. No final inversion is applied.
- R4: A run issues exactly `count` read requests, to addresses start, start+2, start+4 and so on, with at most one request outstanding. `mem_req` is held for one cycle per request, and a new request is issued only after the previous `mem_valid`. The result is correct for any response latency of one cycle or more.
- R5: Fetch overlaps computation. With a response arriving two cycles after the request is issued and the default of 4 bits per cycle, an N-word block completes within 4·N + 10 cycles of the go write.
- R6: A go with a word count of 0 sets done in the next cycle and issues no memory request. The result then equals the seed.
- R7: A go written while busy is ignored. The running job finishes with its original parameters and issues no extra requests.
- R8: The result register keeps its previous value for the whole run and changes only when the block completes.
- R9: Done stays set until software writes 1 to status bit 1. Writing 0 there leaves it set, and an accepted go clears it. Busy and done are never set together.
- R10: `irq` equals done AND the interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| mem_req | output | 1 | Memory read request, one cycle per word |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| irq | output | 1 | Completion interrupt level |

## Verification
Block lengths 1 to 8 are swept against three seeds (all ones, all zeros, and a mixed value) and three memory latency profiles: fixed short, per-address varying, and fixed long. A wrong polynomial, bit order, seed load or word count shows up as a CRC mismatch. A wrong step in the address sequence shows up at the memory model. A long block with minimum latency bounds the completion time, which separates an overlapped fetch from a serial one. Single runs cover a zero length, a go written mid-run with a different seed, a result read during a run, the clear-on-write done semantics and the interrupt gating, each of which a change in control logic would break.

// File: rtl/crcdma_pkg.sv
package crcdma_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_STAT   = 5'h04;
    localparam logic [4:0] OFS_BASE   = 5'h08;
    localparam logic [4:0] OFS_COUNT  = 5'h0C;
    localparam logic [4:0] OFS_SEED   = 5'h10;
    localparam logic [4:0] OFS_RESULT = 5'h14;

    typedef enum logic {
        RUN_IDLE = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [31:0]      base;
        logic [15:0]      count;
        logic [CRC_W-1:0] seed;
    } job_cfg_t;

    // Advance a remainder (data already folded in) by nbits shift steps.
    function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] r,
                                                      input int nbits);
        logic [CRC_W-1:0] t;
        t = r;
        for (int i = 0; i < CRC_W; i++) begin
            if (i < nbits) begin
                t = t[CRC_W-1] ? ({t[CRC_W-2:0], 1'b0} ^ CRC_POLY)
                               : {t[CRC_W-2:0], 1'b0};
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/crcdma_regs.sv
module crcdma_regs
    import crcdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [4:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 busy,
    input  logic                 done,
    input  logic [CRC_W-1:0]     result,
    output job_cfg_t             cfg,
    output logic                 irq_en,
    output logic                 go_pulse,
    output logic                 clr_done
);

    logic wr_en;
    assign wr_en    = bus_sel && bus_wr;
    assign go_pulse = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[0];
    assign clr_done = wr_en && (bus_addr == OFS_STAT) && bus_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            irq_en <= 1'b0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_CTRL:  irq_en    <= bus_wdata[1];
                OFS_BASE:  cfg.base  <= bus_wdata;
                OFS_COUNT: cfg.count <= bus_wdata[15:0];
                OFS_SEED:  cfg.seed  <= bus_wdata[CRC_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_CTRL:   bus_rdata = {30'd0, irq_en, 1'b0};
                OFS_STAT:   bus_rdata = {30'd0, done, busy};
                OFS_BASE:   bus_rdata = cfg.base;
                OFS_COUNT:  bus_rdata = {16'd0, cfg.count};
                OFS_SEED:   bus_rdata = {{(32-CRC_W){1'b0}}, cfg.seed};
                OFS_RESULT: bus_rdata = {{(32-CRC_W){1'b0}}, result};
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/crcdma_fetch.sv
module crcdma_fetch #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              take,
    output logic              buf_valid,
    output logic [DATA_W-1:0] buf_data,
    output logic              drained
);

    localparam int STRIDE = DATA_W / 8;

    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              pend_q;

    assign mem_req  = (left_q != '0) && !pend_q && !buf_valid;
    assign mem_addr = addr_q;
    assign drained  = (left_q == '0) && !pend_q && !buf_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q    <= '0;
            addr_q    <= '0;
            pend_q    <= 1'b0;
            buf_valid <= 1'b0;
            buf_data  <= '0;
        end else if (start) begin
            left_q    <= start_count;
            addr_q    <= start_addr;
            pend_q    <= 1'b0;
            buf_valid <= 1'b0;
        end else begin
            if (mem_req) begin
                pend_q <= 1'b1;
                addr_q <= addr_q + ADDR_W'(STRIDE);
                left_q <= left_q - 1'b1;
            end
            if (mem_valid && pend_q) begin
                pend_q    <= 1'b0;
                buf_valid <= 1'b1;
                buf_data  <= mem_rdata;
            end else if (take) begin
                buf_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/crcdma_core.sv
module crcdma_core
    import crcdma_pkg::*;
#(
    parameter int STEP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CRC_W-1:0] seed,
    input  logic             take,
    input  logic [CRC_W-1:0] word,
    output logic [CRC_W-1:0] rem,
    output logic             active
);

    localparam int NSTEP = CRC_W / STEP;
    localparam int PH_W  = $clog2(NSTEP + 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem    <= '0;
            active <= 1'b0;
            ph_q   <= '0;
        end else if (load) begin
            rem    <= seed;
            active <= 1'b0;
            ph_q   <= '0;
        end else if (take) begin
            rem    <= crc_advance(rem ^ word, STEP);
            active <= (NSTEP > 1);
            ph_q   <= PH_W'(1);
        end else if (active) begin
            rem <= crc_advance(rem, STEP);
            if (ph_q == PH_W'(NSTEP - 1)) begin
                active <= 1'b0;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/crc_dma_engine.sv
module crc_dma_engine
    import crcdma_pkg::*;
#(
    parameter int STEP = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [15:0] mem_rdata,
    output logic        irq
);

    run_state_e       state_q;
    logic             done_q;
    logic [CRC_W-1:0] result_q;
    job_cfg_t         cfg;
    logic             irq_en, go_pulse, clr_done;
    logic             busy, go_ok, launch, take, finish;
    logic             buf_valid, drained, core_active;
    logic [15:0]      buf_data;
    logic [CRC_W-1:0] rem;

    assign busy   = (state_q == RUN_ACTIVE);
    assign go_ok  = go_pulse && !busy;
    assign launch = go_ok && (cfg.count != '0);
    assign take   = busy && buf_valid && !core_active;
    assign finish = busy && drained && !core_active;
    assign irq    = done_q && irq_en;

    crcdma_regs u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done_q), .result(result_q),
        .cfg(cfg), .irq_en(irq_en), .go_pulse(go_pulse), .clr_done(clr_done)
    );

    crcdma_fetch #(.ADDR_W(32), .CNT_W(16), .DATA_W(16)) u_fetch (
        .clk(clk), .rst(rst),
        .start(launch), .start_addr(cfg.base), .start_count(cfg.count),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .take(take), .buf_valid(buf_valid), .buf_data(buf_data),
        .drained(drained)
    );

    crcdma_core #(.STEP(STEP)) u_core (
        .clk(clk), .rst(rst),
        .load(launch), .seed(cfg.seed),
        .take(take), .word(buf_data),
        .rem(rem), .active(core_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RUN_IDLE;
            done_q   <= 1'b0;
            result_q <= '0;
        end else if (go_ok) begin
            if (cfg.count == '0) begin
                done_q   <= 1'b1;
                result_q <= cfg.seed;
            end else begin
                done_q  <= 1'b0;
                state_q <= RUN_ACTIVE;
            end
        end else if (finish) begin
            result_q <= rem;
            done_q   <= 1'b1;
            state_q  <= RUN_IDLE;
        end else if (clr_done) begin
            done_q <= 1'b0;
        end
    end

endmodule

// File: rtl/crcdma_chk.sv
module crcdma_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        mem_req,
    input logic        irq,
    input logic        busy,
    input logic        done,
    input logic [15:0] result,
    input logic [15:0] count
);

    logic go_wr, clr_wr;
    assign go_wr  = bus_sel && bus_wr && (bus_addr == 5'h00) && bus_wdata[0];
    assign clr_wr = bus_sel && bus_wr && (bus_addr == 5'h04) && bus_wdata[1];

    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_req_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_single_outstanding_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(result)));

    p_zero_count_r6: assert property (@(posedge clk) disable iff (rst)
        (go_wr && !busy && count == 16'd0) |=> (done && !busy && !mem_req));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_wr && !go_wr) |=> done);

    p_irq_needs_done_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

endmodule

bind crc_dma_engine crcdma_chk u_chk (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mem_req(mem_req), .irq(irq),
    .busy(busy), .done(done_q), .result(result_q), .count(cfg.count)
);

// File: tb/sim_crc_dma_engine.sv
module sim_crc_dma_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    crc_dma_engine u0 (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] memval(input logic [31:0] a);
        logic [31:0] p;
        p = a[31:1] * 32'h9E37 + 32'h5A3C;
        return p[15:0] ^ {a[8:1], a[16:9]};
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] seed,
                                            input logic [31:0] base, input int n);
        logic [15:0] r, d;
        logic fb;
        r = seed;
        for (int w = 0; w < n; w++) begin
            d = memval(base + 32'(2 * w));
            for (int b = 15; b >= 0; b--) begin
                fb = r[15] ^ d[b];
                r = {r[14:0], 1'b0};
                if (fb) r = r ^ 16'h1021;
            end
        end
        return r;
    endfunction

    // Memory model: variable latency, address sequence checks (R4)
    int          lat_mode = 0;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] exp_addr = '0;
    int          req_seen = 0;

    always @(posedge clk) begin
        mem_valid <= 1'b0;
        if (pend_cnt > 0) begin
            if (pend_cnt == 1) begin
                mem_valid <= 1'b1;
                mem_rdata <= memval(pend_addr);
            end
            pend_cnt <= pend_cnt - 1;
        end
        if (mem_req && !rst) begin
            check(pend_cnt == 0, "R4 request while outstanding", 32'(pend_cnt), 0);
            check(mem_addr == exp_addr, "R4 address sequence", mem_addr, exp_addr);
            exp_addr <= mem_addr + 32'd2;
            req_seen <= req_seen + 1;
            pend_addr <= mem_addr;
            case (lat_mode)
                0: pend_cnt <= 1;
                1: pend_cnt <= 1 + int'(mem_addr[3:1]) % 3;
                default: pend_cnt <= 3;
            endcase
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic setup(input logic [31:0] base, input int n, input logic [15:0] seed);
        bus_write(5'h08, base);
        bus_write(5'h0C, 32'(n));
        bus_write(5'h10, {16'd0, seed});
        exp_addr = base;
        req_seen = 0;
    endtask

    task automatic wait_done(output int cycles);
        logic [31:0] s;
        cycles = 0;
        s = '0;
        while (s[1] == 1'b0 && cycles < 20000) begin
            bus_read(5'h04, s);
            cycles++;
        end
    endtask

    task automatic run_check(input logic [31:0] base, input int n, input logic [15:0] seed,
                             input string tag);
        int cyc;
        logic [31:0] r;
        logic [15:0] e;
        setup(base, n, seed);
        bus_write(5'h00, 32'h1);
        wait_done(cyc);
        bus_read(5'h14, r);
        e = ref_crc(seed, base, n);
        check(r[15:0] == e, tag, r, {16'd0, e});
        check(req_seen == n, "R4 request count", 32'(req_seen), 32'(n));
    endtask

    initial begin
        logic [31:0] r;
        int cyc;
        logic [15:0] seeds [3];
        seeds[0] = 16'hFFFF; seeds[1] = 16'h0000; seeds[2] = 16'h1D0F;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(5'h04, r);  check(r == 0, "R1 status after reset", r, 0);
        bus_read(5'h14, r);  check(r == 0, "R1 result after reset", r, 0);
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
        check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);

        // R2 register readback
        bus_write(5'h08, 32'h0000_1230);
        bus_write(5'h0C, 32'h0000_00A5);
        bus_write(5'h10, 32'h0000_C0DE);
        bus_write(5'h00, 32'h2);
        bus_read(5'h08, r); check(r == 32'h1230, "R2 start address", r, 32'h1230);
        bus_read(5'h0C, r); check(r == 32'hA5, "R2 word count", r, 32'hA5);
        bus_read(5'h10, r); check(r == 32'hC0DE, "R2 seed", r, 32'hC0DE);
        bus_read(5'h00, r); check(r == 32'h2, "R2 control irq enable", r, 32'h2);
        bus_read(5'h04, r); check(r == 0, "R2 go bit not set by enable write", r, 0);
        bus_write(5'h00, 32'h0);

        // R3/R4 sweep over lengths, seeds, latency profiles
        for (int lm = 0; lm < 3; lm++) begin
            lat_mode = lm;
            for (int si = 0; si < 3; si++) begin
                for (int n = 1; n <= 8; n++) begin
                    run_check(32'h100 + 32'(64 * n + 6 * si), n, seeds[si], "R3 crc sweep");
                end
            end
        end

        // R5 overlap: minimum latency, long block
        lat_mode = 0;
        setup(32'h4000, 64, 16'hFFFF);
        bus_write(5'h00, 32'h1);
        wait_done(cyc);
        check(cyc <= 4 * 64 + 10, "R5 completion time", 32'(cyc), 32'(4 * 64 + 10));
        bus_read(5'h14, r);
        check(r[15:0] == ref_crc(16'hFFFF, 32'h4000, 64), "R5 crc", r,
              {16'd0, ref_crc(16'hFFFF, 32'h4000, 64)});

        // R6 zero count
        setup(32'h800, 0, 16'hBEEF);
        bus_write(5'h00, 32'h1);
        bus_read(5'h04, r); check(r == 32'h2, "R6 done after zero count", r, 32'h2);
        bus_read(5'h14, r); check(r == 32'hBEEF, "R6 result equals seed", r, 32'hBEEF);
        check(req_seen == 0, "R6 no requests", 32'(req_seen), 0);

        // R7/R8 go while busy, result held during run
        lat_mode = 2;
        setup(32'h2000, 32, 16'h1234);
        bus_write(5'h00, 32'h1);
        bus_read(5'h04, r); check(r == 32'h1, "R9 busy and done cleared by go", r, 1);
        bus_read(5'h14, r); check(r == 32'hBEEF, "R8 result held while busy", r, 32'hBEEF);
        bus_write(5'h10, 32'h0000_5555);
        bus_write(5'h00, 32'h1);
        bus_read(5'h14, r); check(r == 32'hBEEF, "R8 result held late in run", r, 32'hBEEF);
        wait_done(cyc);
        bus_read(5'h14, r);
        check(r[15:0] == ref_crc(16'h1234, 32'h2000, 32), "R7 go while busy ignored", r,
              {16'd0, ref_crc(16'h1234, 32'h2000, 32)});
        check(req_seen == 32, "R7 no extra requests", 32'(req_seen), 32);

        // R9 done W1C
        bus_write(5'h04, 32'h0);
        bus_read(5'h04, r); check(r == 32'h2, "R9 write 0 keeps done", r, 32'h2);
        bus_write(5'h04, 32'h2);
        bus_read(5'h04, r); check(r == 32'h0, "R9 write 1 clears done", r, 0);

        // R10 interrupt gating
        lat_mode = 1;
        setup(32'h3000, 5, 16'hAAAA);
        bus_write(5'h00, 32'h3);
        wait_done(cyc);
        @(negedge clk);
        check(irq == 1'b1, "R10 irq with enable", 32'(irq), 1);
        bus_write(5'h04, 32'h2);
        check(irq == 1'b0, "R10 irq cleared with done", 32'(irq), 0);
        setup(32'h3000, 3, 16'hAAAA);
        bus_write(5'h00, 32'h1);
        wait_done(cyc);
        @(negedge clk);
        check(irq == 1'b0, "R10 irq masked", 32'(irq), 0);

        // R3 long block
        lat_mode = 1;
        run_check(32'h1_0000, 1024, 16'hFFFF, "R3 long block");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule